// File: doc/BRIEF.md
# Reset and Boot-Source Selection Controller

This block sits at the reset edge of an audio signal-processing subsystem. An active-low external reset input acts as a full system reset: while it is low, every internal reset output stays asserted, the crystal oscillator enable stays on and the PLL enable stays off. When the external reset is released, the input passes through a two-flop synchronizer. On the first cycle that the synchronized release is seen, the block captures a 4-bit strap code, which is also synchronized. That code selects the boot source. There are three sources: a slave on I2C port 1 answering an external master, a master on I2C port 0 reading an EEPROM, and a master on the SPI port reading a flash device.

A small state machine drives the sequence. Its states are HOLD (reset held), START (one cycle, boot-start pulse), RUN (boot source enabled) and FAULT (reserved strap code). Its transitions are:
- HOLD to START on synchronized release with a known code.
- HOLD to FAULT on synchronized release with a reserved code.
- START to RUN on the next clock.
- Any state back to HOLD, asynchronously, while the external reset is low.

A separate path merges three reset causes into the reset output: power-on reset, the 3.3 V brownout detector and the 1.8 V brownout detector. The output is given as an output-enable that pulls the open-drain reset line low.

Top module: `rstboot_ctrl`

## Requirements
- R1: While `ext_rst_n` is low, the outputs are held as follows: `sys_rst_n`=0, `pll_en`=0, `osc_en`=1, `boot_start`=0, `boot_err`=0, `boot_code`=0, `iface_sel`=0 and `boot_mode`=3.
- R2: `ext_rst_n` is released between clock edges. `sys_rst_n` and `boot_start` both rise after the third rising edge that follows the release. `boot_start` is high for exactly one cycle, and only for a known code.
- R3: Strap code 4'b0000 selects an I2C slave boot. The outputs are `boot_mode`=0, `iface_sel`=3'b001 (bit 0 is I2C port 1), `boot_master`=0, `boot_slave_addr`=8'h88 and `boot_clk_div`=0 (clock supplied by the external master).
- R4: Strap code 4'b0001 selects an I2C master boot from an EEPROM. The outputs are `boot_mode`=1, `iface_sel`=3'b010 (bit 1 is I2C port 0), `boot_master`=1, `boot_slave_addr`=0 and `boot_clk_div`=61, which is the 24.576 MHz crystal divided down to about 400 kb/s.
- R5: Strap code 4'b0010 selects an SPI master boot from a flash device. The outputs are `boot_mode`=2, `iface_sel`=3'b100 (bit 2 is SPI), `boot_master`=1, `boot_slave_addr`=0 and `boot_clk_div`=16, which gives 1.536 MHz from 24.576 MHz.
- R6: Strap codes 4'b0011 to 4'b1111 are reserved. For these codes, `boot_start` never pulses and `pll_en` stays 0. `boot_mode` is 3, `iface_sel` is 0 and `boot_master` is 0. `boot_err` rises together with `sys_rst_n` and stays high until `ext_rst_n` goes low.
- R7: Strap changes after the capture cycle have no effect on any boot output until the next reset.
- R8: `rst_out_oe` is 1 exactly when at least one of `por_active`, `bod33_active` or `bod18_active` is 1. This holds combinationally, with no dependence on the clock or on `ext_rst_n`.
- R9: Driving `ext_rst_n` low at any time returns all outputs to the R1 state at once, without waiting for a clock edge.
- R10: `boot_code` shows the captured strap code from the cycle that `sys_rst_n` rises until the next reset. `pll_en` is 1 in START and RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (crystal domain) |
| ext_rst_n | input | 1 | External active-low system reset |
| por_active | input | 1 | Power-on-reset generator active |
| bod33_active | input | 1 | 3.3 V brownout detector active |
| bod18_active | input | 1 | 1.8 V brownout detector active |
| strap_in | input | 4 | Boot strap pins, sampled at reset release |
| rst_out_oe | output | 1 | 1 = pull open-drain reset output low |
| sys_rst_n | output | 1 | Internal active-low reset to the rest of the chip |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| boot_start | output | 1 | One-cycle pulse that starts the boot loader |
| boot_mode | output | 2 | Decoded boot source, 3 = none |
| boot_code | output | 4 | Captured strap code |
| iface_sel | output | 3 | One-hot interface select {SPI, I2C port 0, I2C port 1} |
| boot_master | output | 1 | 1 = block acts as bus master for boot |
| boot_clk_div | output | 8 | Crystal divider for the boot interface clock |
| boot_slave_addr | output | 8 | Slave address used in I2C slave boot |
| boot_err | output | 1 | Sticky reserved-code flag |

## Verification
The reset output and the asynchronous reset entry are combinational, so the bench checks them one nanosecond after changing the inputs. Every boot result is due after the third rising edge that follows a release placed on a falling edge. Two of those edges are synchronizer stages and one is the state register. The bench therefore counts falling edges from the release: two samples show the block still in reset, and the third shows `boot_start`, the decode and the error flag. The sample after that confirms the pulse has ended and the decode is unchanged. The strap-change and sticky-error checks sample again many cycles later, still before the next reset.

// File: rtl/rstboot_pkg.sv
package rstboot_pkg;

    localparam int STRAP_W = 4;
    localparam int IF_W    = 3;

    typedef enum logic [1:0] {
        MODE_I2C_SLV = 2'd0,
        MODE_I2C_MST = 2'd1,
        MODE_SPI_MST = 2'd2,
        MODE_NONE    = 2'd3
    } boot_mode_e;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_START,
        ST_RUN,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        boot_mode_e        mode;
        logic              master;
        logic [IF_W-1:0]   iface;
    } boot_cfg_t;

    localparam boot_cfg_t CFG_NONE = '{valid: 1'b0, mode: MODE_NONE,
                                       master: 1'b0, iface: '0};

endpackage

// File: rtl/rb_sync.sv
module rb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rb_cause_merge.sv
module rb_cause_merge #(
    parameter int N_CAUSE = 3
) (
    input  logic [N_CAUSE-1:0] cause,
    output logic               drive_low
);
    always_comb begin
        drive_low = 1'b0;
        for (int i = 0; i < N_CAUSE; i++) begin
            drive_low = drive_low | cause[i];
        end
    end
endmodule

// File: rtl/rb_boot_decode.sv
module rb_boot_decode
    import rstboot_pkg::*;
(
    input  logic [STRAP_W-1:0] code,
    output boot_cfg_t          cfg
);
    always_comb begin
        cfg = CFG_NONE;
        unique case (code)
            4'b0000: cfg = '{valid: 1'b1, mode: MODE_I2C_SLV, master: 1'b0, iface: 3'b001};
            4'b0001: cfg = '{valid: 1'b1, mode: MODE_I2C_MST, master: 1'b1, iface: 3'b010};
            4'b0010: cfg = '{valid: 1'b1, mode: MODE_SPI_MST, master: 1'b1, iface: 3'b100};
            default: cfg = CFG_NONE;
        endcase
    end
endmodule

// File: rtl/rb_boot_fsm.sv
module rb_boot_fsm
    import rstboot_pkg::*;
(
    input  logic               clk,
    input  logic               arst_n,
    input  logic               rel_sync,
    input  logic [STRAP_W-1:0] code_in,
    input  boot_cfg_t          cfg_in,
    output logic               sys_rst_n,
    output logic               pll_en,
    output logic               boot_start,
    output logic               boot_err,
    output logic [STRAP_W-1:0] code_out,
    output boot_cfg_t          cfg_out
);
    seq_state_e         state_q, state_d;
    logic [STRAP_W-1:0] code_q;
    boot_cfg_t          cfg_q;

    // State register and capture of the strap code
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_HOLD;
            code_q  <= '0;
            cfg_q   <= CFG_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HOLD && rel_sync) begin
                code_q <= code_in;
                cfg_q  <= cfg_in;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (rel_sync) state_d = cfg_in.valid ? ST_START : ST_FAULT;
            ST_START: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            ST_FAULT: state_d = ST_FAULT;
        endcase
    end

    // Outputs
    always_comb begin
        sys_rst_n  = 1'b1;
        pll_en     = 1'b0;
        boot_start = 1'b0;
        boot_err   = 1'b0;
        code_out   = code_q;
        cfg_out    = CFG_NONE;
        unique case (state_q)
            ST_HOLD: begin
                sys_rst_n = 1'b0;
                code_out  = '0;
            end
            ST_START: begin
                pll_en     = 1'b1;
                boot_start = 1'b1;
                cfg_out    = cfg_q;
            end
            ST_RUN: begin
                pll_en  = 1'b1;
                cfg_out = cfg_q;
            end
            ST_FAULT: begin
                boot_err = 1'b1;
            end
        endcase
    end

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!arst_n)
        boot_start |=> !boot_start);

    assert_release_outcome_R2: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(sys_rst_n) |-> (boot_start != boot_err));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!arst_n)
        boot_err |=> boot_err);

    assert_err_blocks_start_R6: assert property (@(posedge clk) disable iff (!arst_n)
        boot_err |-> (!boot_start && !pll_en));

    assert_code_frozen_R7: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q != ST_HOLD && $past(state_q) != ST_HOLD) |-> $stable(code_q));
endmodule

// File: rtl/rstboot_ctrl.sv
module rstboot_ctrl
    import rstboot_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          DIV_W       = 8,
    parameter int          XTAL_HZ     = 24576000,
    parameter int          I2C_BPS     = 400000,
    parameter int          SPI_HZ      = 1536000,
    parameter logic [7:0]  SLAVE_ADDR  = 8'h88
) (
    input  logic             clk,
    input  logic             ext_rst_n,
    input  logic             por_active,
    input  logic             bod33_active,
    input  logic             bod18_active,
    input  logic [3:0]       strap_in,
    output logic             rst_out_oe,
    output logic             sys_rst_n,
    output logic             osc_en,
    output logic             pll_en,
    output logic             boot_start,
    output logic [1:0]       boot_mode,
    output logic [3:0]       boot_code,
    output logic [2:0]       iface_sel,
    output logic             boot_master,
    output logic [DIV_W-1:0] boot_clk_div,
    output logic [7:0]       boot_slave_addr,
    output logic             boot_err
);
    localparam int I2C_DIV = XTAL_HZ / I2C_BPS;
    localparam int SPI_DIV = XTAL_HZ / SPI_HZ;

    logic               rel_sync;
    logic [STRAP_W-1:0] strap_sync;
    boot_cfg_t          strap_cfg;
    boot_cfg_t          cfg_live;

    rb_cause_merge #(.N_CAUSE(3)) u_merge (
        .cause     ({bod18_active, bod33_active, por_active}),
        .drive_low (rst_out_oe)
    );

    rb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
        .clk    (clk),
        .arst_n (ext_rst_n),
        .d      (1'b1),
        .q      (rel_sync)
    );

    rb_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES)) u_strap_sync (
        .clk    (clk),
        .arst_n (ext_rst_n),
        .d      (strap_in),
        .q      (strap_sync)
    );

    rb_boot_decode u_dec (
        .code (strap_sync),
        .cfg  (strap_cfg)
    );

    rb_boot_fsm u_fsm (
        .clk        (clk),
        .arst_n     (ext_rst_n),
        .rel_sync   (rel_sync),
        .code_in    (strap_sync),
        .cfg_in     (strap_cfg),
        .sys_rst_n  (sys_rst_n),
        .pll_en     (pll_en),
        .boot_start (boot_start),
        .boot_err   (boot_err),
        .code_out   (boot_code),
        .cfg_out    (cfg_live)
    );

    assign osc_en      = 1'b1;
    assign boot_mode   = cfg_live.mode;
    assign iface_sel   = cfg_live.iface;
    assign boot_master = cfg_live.master;

    always_comb begin
        boot_clk_div    = '0;
        boot_slave_addr = '0;
        unique case (cfg_live.mode)
            MODE_I2C_SLV: boot_slave_addr = SLAVE_ADDR;
            MODE_I2C_MST: boot_clk_div    = DIV_W'(I2C_DIV);
            MODE_SPI_MST: boot_clk_div    = DIV_W'(SPI_DIV);
            MODE_NONE:    boot_clk_div    = '0;
        endcase
    end

    assert_iface_onehot_R3: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $onehot0(iface_sel));

    assert_master_has_clock_R4: assert property (@(posedge clk) disable iff (!ext_rst_n)
        boot_master |-> (boot_clk_div != '0 && pll_en));
endmodule

// File: tb/rstboot_ctrl_tb_top.sv
`timescale 1ns/1ps
module rstboot_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       ext_rst_n = 1'b0;
    logic       por_active = 1'b0, bod33_active = 1'b0, bod18_active = 1'b0;
    logic [3:0] strap_in = 4'h0;
    logic       rst_out_oe, sys_rst_n, osc_en, pll_en, boot_start, boot_master, boot_err;
    logic [1:0] boot_mode;
    logic [3:0] boot_code;
    logic [2:0] iface_sel;
    logic [7:0] boot_clk_div, boot_slave_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rstboot_ctrl dut_i (
        .clk(clk), .ext_rst_n(ext_rst_n), .por_active(por_active),
        .bod33_active(bod33_active), .bod18_active(bod18_active), .strap_in(strap_in),
        .rst_out_oe(rst_out_oe), .sys_rst_n(sys_rst_n), .osc_en(osc_en), .pll_en(pll_en),
        .boot_start(boot_start), .boot_mode(boot_mode), .boot_code(boot_code),
        .iface_sel(iface_sel), .boot_master(boot_master), .boot_clk_div(boot_clk_div),
        .boot_slave_addr(boot_slave_addr), .boot_err(boot_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_reset_outputs(input string tag);
        chk({tag, " sys_rst_n"}, 32'(sys_rst_n), 0);
        chk({tag, " pll_en"}, 32'(pll_en), 0);
        chk({tag, " osc_en"}, 32'(osc_en), 1);
        chk({tag, " boot_start"}, 32'(boot_start), 0);
        chk({tag, " boot_err"}, 32'(boot_err), 0);
        chk({tag, " boot_code"}, 32'(boot_code), 0);
        chk({tag, " iface_sel"}, 32'(iface_sel), 0);
        chk({tag, " boot_mode"}, 32'(boot_mode), 3);
    endtask

    function automatic bit known(input logic [3:0] c);
        return c <= 4'd2;
    endfunction

    task automatic check_decode(input string tag, input logic [3:0] c);
        logic [1:0] m;
        logic [2:0] ifs;
        logic [7:0] dv;
        logic [7:0] ad;
        m = 2'd3; ifs = 3'b000; dv = 8'd0; ad = 8'd0;
        if (c == 4'd0) begin m = 2'd0; ifs = 3'b001; ad = 8'h88; end
        if (c == 4'd1) begin m = 2'd1; ifs = 3'b010; dv = 8'd61; end
        if (c == 4'd2) begin m = 2'd2; ifs = 3'b100; dv = 8'd16; end
        chk({tag, " mode"}, 32'(boot_mode), 32'(m));
        chk({tag, " iface"}, 32'(iface_sel), 32'(ifs));
        chk({tag, " master"}, 32'(boot_master), 32'((c == 4'd1) || (c == 4'd2)));
        chk({tag, " clkdiv"}, 32'(boot_clk_div), 32'(dv));
        chk({tag, " addr"}, 32'(boot_slave_addr), 32'(ad));
        chk({tag, " err R6"}, 32'(boot_err), 32'(!known(c)));
        chk({tag, " pll R10"}, 32'(pll_en), 32'(known(c)));
        chk({tag, " code R10"}, 32'(boot_code), 32'(c));
    endtask

    // R1 R2 R3 R4 R5 R6: hold reset with a strap code, release, follow the pulse
    task automatic boot_with_code(input logic [3:0] c);
        string tag;
        tag = (c == 0) ? "R3" : (c == 1) ? "R4" : (c == 2) ? "R5" : "R6";
        @(negedge clk);
        ext_rst_n = 1'b0;
        strap_in = c;
        repeat (4) @(negedge clk);
        check_reset_outputs("R1 held");
        ext_rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 still in reset", 32'(sys_rst_n), 0);
        chk("R2 no early start", 32'(boot_start), 0);
        @(negedge clk);
        chk("R2 released", 32'(sys_rst_n), 1);
        chk("R2 start pulse", 32'(boot_start), 32'(known(c)));
        check_decode(tag, c);
        @(negedge clk);
        chk("R2 pulse ended", 32'(boot_start), 0);
        check_decode(tag, c);
    endtask

    task automatic all_codes();
        for (int c = 0; c < 16; c++) boot_with_code(4'(c));
    endtask

    // R7: straps move after capture
    task automatic strap_change_ignored();
        boot_with_code(4'd1);
        for (int v = 0; v < 16; v++) begin
            strap_in = 4'(v);
            repeat (3) @(negedge clk);
        end
        chk("R7 start stays low", 32'(boot_start), 0);
        check_decode("R7", 4'd1);
    endtask

    // R6: reserved code error stays set
    task automatic reserved_sticky();
        boot_with_code(4'd9);
        strap_in = 4'd0;
        repeat (20) @(negedge clk);
        chk("R6 err sticky", 32'(boot_err), 1);
        chk("R6 no start", 32'(boot_start), 0);
        chk("R6 pll off", 32'(pll_en), 0);
    endtask

    // R9: asynchronous return to reset mid-run
    task automatic async_reset_entry();
        boot_with_code(4'd2);
        repeat (3) @(negedge clk);
        @(posedge clk);
        #1;
        ext_rst_n = 1'b0;
        #0.5;
        check_reset_outputs("R9 async");
        boot_with_code(4'd5);
        @(posedge clk);
        #1;
        ext_rst_n = 1'b0;
        #0.5;
        chk("R9 err cleared", 32'(boot_err), 0);
    endtask

    // R8: every cause combination, in and out of reset
    task automatic reset_out_causes();
        for (int r = 0; r < 2; r++) begin
            ext_rst_n = r[0];
            for (int k = 0; k < 8; k++) begin
                {bod18_active, bod33_active, por_active} = 3'(k);
                #1;
                chk("R8 rst_out_oe", 32'(rst_out_oe), 32'(k != 0));
            end
        end
        {bod18_active, bod33_active, por_active} = 3'b000;
    endtask

    initial begin
        #1;
        check_reset_outputs("R1 time zero");
        chk("R8 idle", 32'(rst_out_oe), 0);
        all_codes();
        strap_change_ignored();
        reserved_sticky();
        async_reset_entry();
        reset_out_causes();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule